// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between a register-file datapath and a word-wide, byte-addressed data memory that answers a read one clock after the request. It decodes four memory operations: word load, word store, byte load and byte store. The address of the access is a 32-bit base plus a 16-bit signed displacement. The unit sends the memory a word address, per-lane write enables and write data in the same cycle as the request. In the following cycle it turns the returned word into the value the register file receives.

Lanes are numbered big-endian: byte offset 0 of a word sits in bits [31:24] and byte offset 3 sits in bits [7:0]. A byte store updates exactly one lane. A byte load returns the selected lane sign-extended to 32 bits. A word access whose address is not a multiple of four is flagged and blocked. It writes nothing, and a blocked load returns zero.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `base + sext32(offset)`, and `mem_addr` carries bits [31:2] of that sum in the request cycle for every opcode.
- R2: A word store (opcode 43) at an address whose low two bits are 00 drives `mem_be` = 4'b1111 and `mem_wdata` = `st_data`.
- R3: A byte store (opcode 0x28) drives exactly one `mem_be` bit, bit (3 - ea[1:0]), where `mem_be[3]` covers bits [31:24]. It drives `mem_wdata` with `st_data[7:0]` repeated in all four lanes.
- R4: A word load (opcode 35) that is aligned raises `ld_valid` in the cycle after the request, and `ld_result` equals `mem_rdata` in that cycle.
- R5: A byte load (opcode 0x20) raises `ld_valid` in the cycle after the request. `ld_result[7:0]` is `mem_rdata[31-8*ea[1:0] -: 8]`, and bit 7 of that byte is copied into `ld_result[31:8]`.
- R6: A word load or store with ea[1:0] != 00 raises `misaligned` in the request cycle and drives `mem_be` = 0. For a load, the next cycle shows `ld_valid` = 1 with `ld_result` = 0.
- R7: Any other opcode raises no `mem_be` bit, drives `mem_wdata` = 0, keeps `misaligned` low, and gives no `ld_valid` in the next cycle.
- R8: Byte loads and byte stores never raise `misaligned`, whatever the address.
- R9: While and after reset, with no load issued, `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Operation code of the current request |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_data | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word returned by memory, one cycle after the request |
| mem_addr | output | 30 | Word address to memory |
| mem_be | output | 4 | Per-lane write enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Write data to memory |
| ld_result | output | 32 | Load value for the register file |
| ld_valid | output | 1 | `ld_result` holds a load result this cycle |
| misaligned | output | 1 | Current word request is not word aligned |

## Verification
The embedded properties check on every cycle that a byte store enables exactly one lane, and that a blocked word access writes nothing and a blocked load comes back as zero. They also check that byte operations are never flagged, that undefined opcodes stay quiet, and that every byte-load result is sign-consistent. Only the bench scenarios can show that the right lane is chosen for each byte offset and that the address sum carries and wraps correctly with negative displacements. They also show that the value returned on a load matches the memory word delivered a cycle later.

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit #(
  parameter int unsigned DW       = 32,
  parameter int unsigned OFFW     = 16,
  parameter logic [5:0]  OP_LDW   = 6'd35,
  parameter logic [5:0]  OP_STW   = 6'd43,
  parameter logic [5:0]  OP_LDB   = 6'h20,
  parameter logic [5:0]  OP_STB   = 6'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        opcode,
  input  logic [DW-1:0]     base,
  input  logic [OFFW-1:0]   offset,
  input  logic [DW-1:0]     st_data,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-3:0]     mem_addr,
  output logic [DW/8-1:0]   mem_be,
  output logic [DW-1:0]     mem_wdata,
  output logic [DW-1:0]     ld_result,
  output logic              ld_valid,
  output logic              misaligned
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] ea;
  logic [1:0]    boff;
  logic          is_ldw, is_stw, is_ldb, is_stb, word_op;

  assign ea      = base + {{(DW-OFFW){offset[OFFW-1]}}, offset};
  assign boff    = ea[1:0];
  assign is_ldw  = (opcode == OP_LDW);
  assign is_stw  = (opcode == OP_STW);
  assign is_ldb  = (opcode == OP_LDB);
  assign is_stb  = (opcode == OP_STB);
  assign word_op = is_ldw | is_stw;

  assign mem_addr   = ea[DW-1:2];
  assign misaligned = word_op && (boff != 2'b00);

  always_comb begin
    mem_be    = '0;
    mem_wdata = '0;
    if (is_stw) begin
      mem_wdata = st_data;
      if (!misaligned) mem_be = '1;
    end else if (is_stb) begin
      mem_wdata = {NB{st_data[7:0]}};
      mem_be[2'd3 - boff] = 1'b1;
    end
  end

  logic       v_q, byte_q, zero_q;
  logic [1:0] lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      byte_q <= 1'b0;
      zero_q <= 1'b0;
      lane_q <= 2'b00;
    end else begin
      v_q    <= is_ldw | is_ldb;
      byte_q <= is_ldb;
      zero_q <= is_ldw & misaligned;
      lane_q <= boff;
    end
  end

  logic [7:0] picked;
  always_comb begin
    case (lane_q)
      2'd0:    picked = mem_rdata[31:24];
      2'd1:    picked = mem_rdata[23:16];
      2'd2:    picked = mem_rdata[15:8];
      default: picked = mem_rdata[7:0];
    endcase
  end

  assign ld_valid  = v_q;
  assign ld_result = !v_q   ? '0 :
                     zero_q ? '0 :
                     byte_q ? {{(DW-8){picked[7]}}, picked} : mem_rdata;

  assert_stb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_stb |-> $countones(mem_be) == 1);

  assert_blocked_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> mem_be == '0);

  assert_blocked_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ldw && misaligned) |=> (ld_valid && ld_result == '0));

  assert_byte_unflagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ldb || is_stb) |-> !misaligned);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_op || is_ldb || is_stb) |-> (mem_be == '0 && !misaligned));

  assert_idle_noload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_op || is_ldb || is_stb) |=> !ld_valid);

  assert_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && byte_q) |-> ld_result[DW-1:8] == {(DW-8){ld_result[7]}});
endmodule

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;
  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] sd;
    logic [31:0] rd;
    logic [29:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_wd;
    logic [31:0] e_ld;
    logic        e_lv;
    logic        e_mis;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{6'd35, 32'h12004094, 16'h0018, 32'h0, 32'hCAFEF00D, 30'h0480102B, 4'h0, 32'h0, 32'hCAFEF00D, 1'b1, 1'b0},
    '{6'd35, 32'h00000000, 16'h7FFC, 32'h0, 32'h13579BDF, 30'h00001FFF, 4'h0, 32'h0, 32'h13579BDF, 1'b1, 1'b0},
    '{6'd43, 32'h00001000, 16'hFFFC, 32'h11223344, 32'h0, 30'h000003FF, 4'hF, 32'h11223344, 32'h0, 1'b0, 1'b0},
    '{6'h28, 32'h00000100, 16'h0001, 32'hABCDEF5A, 32'h0, 30'h00000040, 4'h4, 32'h5A5A5A5A, 32'h0, 1'b0, 1'b0},
    '{6'h28, 32'h00000100, 16'h0003, 32'h000000C3, 32'h0, 30'h00000040, 4'h1, 32'hC3C3C3C3, 32'h0, 1'b0, 1'b0},
    '{6'h28, 32'h00000100, 16'h0000, 32'hFFFFFF07, 32'h0, 30'h00000040, 4'h8, 32'h07070707, 32'h0, 1'b0, 1'b0},
    '{6'h20, 32'h00000200, 16'h0000, 32'h0, 32'h8F112233, 30'h00000080, 4'h0, 32'h0, 32'hFFFFFF8F, 1'b1, 1'b0},
    '{6'h20, 32'h00000200, 16'h0002, 32'h0, 32'h01237F45, 30'h00000080, 4'h0, 32'h0, 32'h0000007F, 1'b1, 1'b0},
    '{6'h20, 32'h00000200, 16'h0003, 32'h0, 32'h000000FF, 30'h00000080, 4'h0, 32'h0, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{6'h20, 32'h7FFFFFFF, 16'h0001, 32'h0, 32'h80FFFFFF, 30'h20000000, 4'h0, 32'h0, 32'hFFFFFF80, 1'b1, 1'b0},
    '{6'd35, 32'h00000100, 16'h0002, 32'h0, 32'hFFFFFFFF, 30'h00000040, 4'h0, 32'h0, 32'h00000000, 1'b1, 1'b1},
    '{6'd43, 32'h00000100, 16'hFFFF, 32'h55AA55AA, 32'h0, 30'h0000003F, 4'h0, 32'h55AA55AA, 32'h0, 1'b0, 1'b1},
    '{6'd0,  32'h00000040, 16'h0000, 32'h12345678, 32'hFFFFFFFF, 30'h00000010, 4'h0, 32'h0, 32'h0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] base = '0, st_data = '0, mem_rdata = '0;
  logic [15:0] offset = '0;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, ld_result;
  logic        ld_valid, misaligned;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  lsu_lane_unit u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .base(base), .offset(offset),
    .st_data(st_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .ld_result(ld_result), .ld_valid(ld_valid), .misaligned(misaligned)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] op, input logic mis);
    if (mis)               return "R6";
    else if (op == 6'd43)  return "R2";
    else if (op == 6'h28)  return "R3";
    else if (op == 6'd35)  return "R4";
    else if (op == 6'h20)  return "R5";
    else                   return "R7";
  endfunction

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R9", "ld_valid in reset", {31'b0, ld_valid}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R9", "ld_valid after reset", {31'b0, ld_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string t;
      @(negedge clk);
      opcode = VECS[i].op; base = VECS[i].base; offset = VECS[i].off;
      st_data = VECS[i].sd; mem_rdata = '0;
      t = tag_of(VECS[i].op, VECS[i].e_mis);
      #1;
      chk("R1", "mem_addr", {2'b0, mem_addr}, {2'b0, VECS[i].e_addr});
      chk(t, "mem_be", {28'b0, mem_be}, {28'b0, VECS[i].e_be});
      chk(t, "mem_wdata", mem_wdata, VECS[i].e_wd);
      chk(t, "misaligned", {31'b0, misaligned}, {31'b0, VECS[i].e_mis});
      @(negedge clk);
      opcode = 6'd0; mem_rdata = VECS[i].rd;
      #1;
      chk(t, "ld_valid", {31'b0, ld_valid}, {31'b0, VECS[i].e_lv});
      if (VECS[i].e_lv) chk(t, "ld_result", ld_result, VECS[i].e_ld);
    end

    // R8: byte accesses at every offset never flagged
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opcode = (k[0]) ? 6'h28 : 6'h20; base = 32'h00000301; offset = 16'(k);
      #1 chk("R8", "misaligned on byte op", {31'b0, misaligned}, 32'h0);
    end

    // R3: byte store lanes for each offset, replicated data
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opcode = 6'h28; base = 32'h00000400; offset = 16'(k); st_data = 32'h9ABCDE3C;
      #1;
      chk("R3", "lane enable", {28'b0, mem_be}, {28'b0, 4'b1000 >> k});
      chk("R3", "replicated data", mem_wdata, 32'h3C3C3C3C);
    end

    // R5: byte load from each lane of one word
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w, e;
      logic [7:0]  b;
      w = 32'hF1027A83;
      b = w[31 - 8*k -: 8];
      e = {{24{b[7]}}, b};
      @(negedge clk);
      opcode = 6'h20; base = 32'h00000500; offset = 16'(k);
      @(negedge clk);
      opcode = 6'd0; mem_rdata = w;
      #1 chk("R5", "byte lane load", ld_result, e);
    end

    // R7: undefined opcode after a load leaves no load pending
    @(negedge clk);
    opcode = 6'h3F; base = 32'h00000002; offset = 16'h0; st_data = 32'hFFFFFFFF;
    #1 chk("R7", "mem_be on undefined opcode", {28'b0, mem_be}, 32'h0);
    @(negedge clk);
    opcode = 6'd0;
    #1 chk("R7", "ld_valid after undefined opcode", {31'b0, ld_valid}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule